// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command front end of a byte-wide flash device. Every accepted write strobe delivers a 17-bit address and a data byte. The decoder walks the keyed unlock protocol those writes form. When a sequence completes, it raises a one-cycle request to the embedded-operation controller to program a byte, erase the whole array or erase one 16 KB sector. The request carries the target address, the data byte, a chip-wide flag and the sector number.

The decoder also decides what a read returns. In the normal mode, read data is the array word. In the identifier mode, it is a small table of codes: a maker code, a part code and a per-sector protection flag taken from an input mask. A wrong step anywhere in a sequence drops the decoder back to array reads. Only the reset byte leaves the identifier mode. While the controller reports busy, every write is dropped.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After synchronous reset the decoder is in array-read mode (`id_mode` low) and both start pulses are low.
- R2: Unlock and command writes compare only address bits 14:0. The first key is 0xAA at 0x5555, the second is 0x55 at 0x2AAA, and bits 16:15 are ignored in these compares.
- R3: Keys, then 0xA0 at 0x5555, then any write W: `prog_go` is high for the cycle after W's clock edge. `op_addr` equals W's address, `op_data` equals W's data, `op_sector` equals address bits 16:14 and `op_chip` is 0.
- R4: Keys, 0x80 at 0x5555, keys again, then 0x10 at 0x5555: `erase_go` pulses with `op_chip`=1, and `op_addr`/`op_data` taken from that last write.
- R5: Keys, 0x80 at 0x5555, keys again, then 0x30 at any address: `erase_go` pulses with `op_chip`=0 and `op_sector` equal to bits 16:14 of that address.
- R6: Any write whose address or data does not fit the next expected step returns the decoder to array-read mode, and no start is issued.
- R7: A write of 0xF0 returns the decoder to array-read mode from every state except the one that expects the program target. In that state the write is the program target.
- R8: Keys followed by 0x90 at 0x5555 enter identifier mode (`id_mode` high). Any write other than 0xF0 leaves it in that mode, and 0xF0 at any address leaves it.
- R9: In identifier mode, `rd_data` is based on read address bits 7:0. Offset 0x00 gives 0x01 and offset 0x01 gives 0x20. Offset 0x02 gives 0x01 if `prot_mask` bit [addr 16:14] is set and 0x00 if it is clear. Any other offset gives 0x00. Reads can repeat without limit.
- R10: In array-read mode, `rd_data` equals the value `array_data` had at the previous clock edge (one register of latency). The same latency applies in identifier mode.
- R11: While `busy` is high, writes are ignored, including 0xF0: neither the mode nor the sequence progress changes.
- R12: `prog_go` and `erase_go` are never high in two consecutive cycles and never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per bus write |
| wr_addr | input | 17 | Write address |
| wr_data | input | 8 | Write data |
| busy | input | 1 | Embedded operation in progress |
| rd_addr | input | 17 | Read address |
| array_data | input | 8 | Word read from the array at `rd_addr` |
| prot_mask | input | 8 | Per-sector protection flags |
| rd_data | output | 8 | Registered read data |
| id_mode | output | 1 | Identifier mode active |
| prog_go | output | 1 | Byte program start pulse |
| erase_go | output | 1 | Erase start pulse |
| op_addr | output | 17 | Latched target address |
| op_data | output | 8 | Latched data byte |
| op_chip | output | 1 | Erase covers the whole array |
| op_sector | output | 3 | Target sector number |

## Verification
The bench drives unlocks with the upper two address bits set. A decoder that compared the full address would drop these sequences, and no start request would reach the scoreboard. The bench breaks sequences at the second key, at the command byte and at the erase confirm. Each break is followed by what would complete a program if the decoder had not returned to array reads, so any stray start pulse is caught as unexpected. It writes 0xF0 in the program data slot, writes non-reset bytes inside identifier mode, and writes a full program sequence and a reset while busy is held. Each of these catches a decoder that aborts, exits or advances when it must not. Identifier reads cover a protected sector and an unprotected one, which exposes a wrong sector index into the mask.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [2:0] {
    ST_READ,   // array read, idle
    ST_KEY1,   // first key seen
    ST_KEY2,   // second key seen, expecting command byte
    ST_PROG,   // next write is the program target
    ST_ERS0,   // erase setup seen, expecting first key again
    ST_ERS1,   // expecting second key again
    ST_ERS2,   // expecting erase confirm
    ST_IDENT   // identifier read mode
  } cmd_state_e;

  localparam logic [7:0]  KEY_A      = 8'hAA;
  localparam logic [7:0]  KEY_B      = 8'h55;
  localparam logic [7:0]  CMD_IDENT  = 8'h90;
  localparam logic [7:0]  CMD_PROG   = 8'hA0;
  localparam logic [7:0]  CMD_ERASE  = 8'h80;
  localparam logic [7:0]  CMD_CHIP   = 8'h10;
  localparam logic [7:0]  CMD_SECTOR = 8'h30;
  localparam logic [7:0]  CMD_RESET  = 8'hF0;
  localparam logic [14:0] LOC_A      = 15'h5555;
  localparam logic [14:0] LOC_B      = 15'h2AAA;

endpackage

// File: rtl/flash_cmd_match.sv
module flash_cmd_match
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int CMP_W  = 15,
  parameter int DATA_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              key_a_hit,
  output logic              key_b_hit,
  output logic              at_loc_a,
  output logic              is_reset
);
  logic loc_a, loc_b;

  // only the low CMP_W address bits take part in command compares
  assign loc_a     = (addr[CMP_W-1:0] == LOC_A[CMP_W-1:0]);
  assign loc_b     = (addr[CMP_W-1:0] == LOC_B[CMP_W-1:0]);
  assign key_a_hit = loc_a && (data == KEY_A);
  assign key_b_hit = loc_b && (data == KEY_B);
  assign at_loc_a  = loc_a;
  assign is_reset  = (data == CMD_RESET);

endmodule

// File: rtl/flash_id_mux.sv
module flash_id_mux #(
  parameter int          ADDR_W   = 17,
  parameter int          DATA_W   = 8,
  parameter int          SECTORS  = 8,
  parameter logic [7:0]  MFR_CODE = 8'h01,
  parameter logic [7:0]  DEV_CODE = 8'h20
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sel_id,
  input  logic [ADDR_W-1:0]  rd_addr,
  input  logic [DATA_W-1:0]  array_data,
  input  logic [SECTORS-1:0] prot_mask,
  output logic [DATA_W-1:0]  rd_data
);
  localparam int SECT_W = $clog2(SECTORS);

  logic [SECT_W-1:0]  rd_sect;
  logic [SECTORS-1:0] hit_vec;
  logic               prot_hit;
  logic [DATA_W-1:0]  id_word;

  assign rd_sect = rd_addr[ADDR_W-1 -: SECT_W];

  generate
    for (genvar s = 0; s < SECTORS; s++) begin : g_sect
      assign hit_vec[s] = prot_mask[s] && (rd_sect == SECT_W'(s));
    end
  endgenerate

  assign prot_hit = |hit_vec;

  always_comb begin
    case (rd_addr[7:0])
      8'h00:   id_word = DATA_W'(MFR_CODE);
      8'h01:   id_word = DATA_W'(DEV_CODE);
      8'h02:   id_word = DATA_W'(prot_hit);
      default: id_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= sel_id ? id_word : array_data;
  end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W  = 17,
  parameter int DATA_W  = 8,
  parameter int SECTORS = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic                       busy,
  input  logic [ADDR_W-1:0]          rd_addr,
  input  logic [DATA_W-1:0]          array_data,
  input  logic [SECTORS-1:0]         prot_mask,
  output logic [DATA_W-1:0]          rd_data,
  output logic                       id_mode,
  output logic                       prog_go,
  output logic                       erase_go,
  output logic [ADDR_W-1:0]          op_addr,
  output logic [DATA_W-1:0]          op_data,
  output logic                       op_chip,
  output logic [$clog2(SECTORS)-1:0] op_sector
);
  localparam int SECT_W = $clog2(SECTORS);

  cmd_state_e state, nxt;
  logic key_a_hit, key_b_hit, at_loc_a, is_reset;
  logic take, fire_prog, fire_erase, fire_chip;

  flash_cmd_match #(.ADDR_W(ADDR_W), .CMP_W(15), .DATA_W(DATA_W)) match_i (
    .addr      (wr_addr),
    .data      (wr_data),
    .key_a_hit (key_a_hit),
    .key_b_hit (key_b_hit),
    .at_loc_a  (at_loc_a),
    .is_reset  (is_reset)
  );

  assign take = wr_en && !busy;

  always_comb begin
    nxt        = state;
    fire_prog  = 1'b0;
    fire_erase = 1'b0;
    fire_chip  = 1'b0;
    if (take) begin
      case (state)
        ST_READ:  nxt = key_a_hit ? ST_KEY1 : ST_READ;
        ST_KEY1:  nxt = key_b_hit ? ST_KEY2 : ST_READ;
        ST_KEY2: begin
          nxt = ST_READ;
          if (at_loc_a) begin
            if (wr_data == CMD_IDENT)      nxt = ST_IDENT;
            else if (wr_data == CMD_PROG)  nxt = ST_PROG;
            else if (wr_data == CMD_ERASE) nxt = ST_ERS0;
          end
        end
        ST_PROG: begin
          fire_prog = 1'b1;
          nxt       = ST_READ;
        end
        ST_ERS0:  nxt = key_a_hit ? ST_ERS1 : ST_READ;
        ST_ERS1:  nxt = key_b_hit ? ST_ERS2 : ST_READ;
        ST_ERS2: begin
          nxt = ST_READ;
          if (at_loc_a && wr_data == CMD_CHIP) begin
            fire_erase = 1'b1;
            fire_chip  = 1'b1;
          end else if (wr_data == CMD_SECTOR) begin
            fire_erase = 1'b1;
          end
        end
        ST_IDENT: nxt = is_reset ? ST_READ : ST_IDENT;
        default:  nxt = ST_READ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_READ;
      id_mode   <= 1'b0;
      prog_go   <= 1'b0;
      erase_go  <= 1'b0;
      op_addr   <= '0;
      op_data   <= '0;
      op_chip   <= 1'b0;
      op_sector <= '0;
    end else begin
      state    <= nxt;
      id_mode  <= (nxt == ST_IDENT);
      prog_go  <= fire_prog;
      erase_go <= fire_erase;
      if (fire_prog || fire_erase) begin
        op_addr   <= wr_addr;
        op_data   <= wr_data;
        op_chip   <= fire_chip;
        op_sector <= wr_addr[ADDR_W-1 -: SECT_W];
      end
    end
  end

  flash_id_mux #(
    .ADDR_W (ADDR_W), .DATA_W (DATA_W), .SECTORS (SECTORS),
    .MFR_CODE (8'h01), .DEV_CODE (8'h20)
  ) idmux_i (
    .clk        (clk),
    .rst        (rst),
    .sel_id     (state == ST_IDENT),
    .rd_addr    (rd_addr),
    .array_data (array_data),
    .prot_mask  (prot_mask),
    .rd_data    (rd_data)
  );

  AST_START_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(prog_go && erase_go)); // R12
  AST_PROG_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    prog_go |=> !prog_go); // R12
  AST_ERASE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    erase_go |=> !erase_go); // R12
  AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(state)); // R11
  AST_PROG_SOURCE: assert property (@(posedge clk) disable iff (rst)
    $rose(prog_go) |-> $past(state) == ST_PROG); // R3
  AST_ERASE_SOURCE: assert property (@(posedge clk) disable iff (rst)
    $rose(erase_go) |-> $past(state) == ST_ERS2); // R4
  AST_IDENT_STICKY: assert property (@(posedge clk) disable iff (rst)
    (id_mode && !wr_en) |=> id_mode); // R8

endmodule

// File: tb/flash_cmd_decoder_tb.sv
`timescale 1ns/1ps
module flash_cmd_decoder_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [16:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        busy = 1'b0;
  logic [16:0] rd_addr = '0;
  logic [7:0]  array_data;
  logic [7:0]  prot_mask = 8'b1000_0100;
  logic [7:0]  rd_data;
  logic        id_mode, prog_go, erase_go, op_chip;
  logic [16:0] op_addr;
  logic [7:0]  op_data;
  logic [2:0]  op_sector;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  bit prev_go = 0;

  typedef struct {
    logic        is_erase;
    logic        chip;
    logic [16:0] addr;
    logic [7:0]  data;
  } ev_t;
  ev_t exp_q[$];

  always #4 clk = ~clk;

  // array model: data depends on address
  assign array_data = rd_addr[7:0] ^ 8'h5A;

  flash_cmd_decoder dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .rd_addr(rd_addr), .array_data(array_data), .prot_mask(prot_mask),
    .rd_data(rd_data), .id_mode(id_mode), .prog_go(prog_go), .erase_go(erase_go),
    .op_addr(op_addr), .op_data(op_data), .op_chip(op_chip), .op_sector(op_sector)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // monitor: compares every start pulse against the scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (prog_go || erase_go) begin
        chk(!(prev_go), "R12 back-to-back start", 1, 0);
        chk(!(prog_go && erase_go), "R12 both starts", 1, 0);
        if (exp_q.size() == 0) begin
          chk(0, "R6 unexpected start", {prog_go, erase_go}, 0);
        end else begin
          ev_t e;
          e = exp_q.pop_front();
          chk(erase_go == e.is_erase, "R3/R4/R5 start kind", erase_go, e.is_erase);
          chk(op_addr == e.addr, "R3/R5 op_addr", op_addr, e.addr);
          chk(op_data == e.data, "R3 op_data", op_data, e.data);
          chk(op_chip == e.chip, "R4/R5 op_chip", op_chip, e.chip);
          chk(op_sector == e.addr[16:14], "R3/R5 op_sector", op_sector, e.addr[16:14]);
        end
      end
      prev_go = prog_go || erase_go;
    end
  end

  task automatic wr(input logic [16:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic expect_ev(input logic er, input logic ch, input logic [16:0] a, input logic [7:0] d);
    ev_t e;
    e.is_erase = er; e.chip = ch; e.addr = a; e.data = d;
    exp_q.push_back(e);
  endtask

  task automatic rd_chk(input logic [16:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    chk(rd_data == exp, req, rd_data, exp);
  endtask

  task automatic keys();
    wr(17'h05555, 8'hAA);
    wr(17'h02AAA, 8'h55);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(id_mode == 1'b0, "R1 id_mode after reset", id_mode, 0);
    chk(!prog_go && !erase_go, "R1 starts after reset", {prog_go, erase_go}, 0);
    rd_chk(17'h00013, 8'h13 ^ 8'h5A, "R10 array read");

    // R3 program
    keys(); wr(17'h05555, 8'hA0);
    expect_ev(0, 0, 17'h0ABCD, 8'h3C);
    wr(17'h0ABCD, 8'h3C);
    chk(prog_go == 1'b1, "R3 prog_go pulse", prog_go, 1);
    @(negedge clk);
    chk(prog_go == 1'b0, "R12 prog_go one cycle", prog_go, 0);

    // R2 upper address bits ignored in unlock compares
    wr(17'h1D555, 8'hAA); wr(17'h0AAAA, 8'h55); wr(17'h18000 | 17'h5555, 8'hA0);
    expect_ev(0, 0, 17'h1FFFF, 8'h00);
    wr(17'h1FFFF, 8'h00);

    // R4 chip erase
    keys(); wr(17'h05555, 8'h80); keys();
    expect_ev(1, 1, 17'h05555, 8'h10);
    wr(17'h05555, 8'h10);
    chk(erase_go == 1'b1, "R4 erase_go pulse", erase_go, 1);

    // R5 sector erase, sector 7
    keys(); wr(17'h05555, 8'h80); keys();
    expect_ev(1, 0, 17'h1C123, 8'h30);
    wr(17'h1C123, 8'h30);

    // R6 wrong second-key address, then would-be program writes
    wr(17'h05555, 8'hAA); wr(17'h02AAB, 8'h55);
    wr(17'h05555, 8'hA0); wr(17'h00100, 8'h11);
    chk(id_mode == 1'b0, "R6 mismatch stays array", id_mode, 0);
    // R6 wrong erase confirm
    keys(); wr(17'h05555, 8'h80); keys(); wr(17'h05555, 8'h20);
    keys(); wr(17'h05555, 8'h55); wr(17'h00200, 8'h22);

    // R7 reset mid-sequence aborts
    keys(); wr(17'h01234, 8'hF0);
    wr(17'h05555, 8'hA0); wr(17'h00300, 8'h33);
    // R7 0xF0 in program slot is program data
    keys(); wr(17'h05555, 8'hA0);
    expect_ev(0, 0, 17'h04444, 8'hF0);
    wr(17'h04444, 8'hF0);

    // R8 / R9 identifier mode
    keys(); wr(17'h15555, 8'h90);
    chk(id_mode == 1'b1, "R8 enter id mode", id_mode, 1);
    rd_chk(17'h00000, 8'h01, "R9 maker code");
    rd_chk(17'h00001, 8'h20, "R9 part code");
    rd_chk(17'h1C002, 8'h01, "R9 sector 7 protected");
    rd_chk(17'h04002, 8'h00, "R9 sector 1 unprotected");
    rd_chk(17'h08002, 8'h01, "R9 sector 2 protected");
    rd_chk(17'h12301, 8'h20, "R9 repeat part code");
    keys(); wr(17'h05555, 8'hA0); wr(17'h00400, 8'h44);
    chk(id_mode == 1'b1, "R8 non-reset writes ignored", id_mode, 1);
    rd_chk(17'h00000, 8'h01, "R8 still identifier data");

    // R11 reset ignored while busy
    busy = 1'b1;
    wr(17'h00000, 8'hF0);
    busy = 1'b0;
    chk(id_mode == 1'b1, "R11 reset ignored when busy", id_mode, 1);
    wr(17'h00777, 8'hF0);
    chk(id_mode == 1'b0, "R8 reset exits id mode", id_mode, 0);
    rd_chk(17'h00042, 8'h42 ^ 8'h5A, "R10 array read after exit");

    // R11 full program sequence while busy
    busy = 1'b1;
    keys(); wr(17'h05555, 8'hA0); wr(17'h00500, 8'h55);
    busy = 1'b0;
    wr(17'h00600, 8'h66);
    chk(!prog_go, "R11 busy writes dropped", prog_go, 0);

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R3/R4/R5 missing starts", exp_q.size(), 0);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule